// File: doc/BRIEF.md
# Two-Wire Serial Bus Master

This block is a master-only controller for an open-drain two-wire serial bus (clock line and data line) in the I2C style. A host steers it one command at a time: generate a start (or repeated start) condition, shift out one byte and sample the acknowledge, shift in one byte and answer it with ACK or NACK, or generate a stop condition. The block never acts as a target and does no arbitration. If another master drives the data line low during a transfer, the block does not notice.

The block runs from a 12 MHz reference clock. One bus-clock period lasts `(lin + 1) * 2^exp` reference cycles. With `lin = 14`, `exp = 3` the period is 120 cycles, which gives 100 kbit/s. With `lin = 14`, `exp = 1` the period is 30 cycles, which gives 400 kbit/s. The block only pulls a line low or lets it go. External pull-ups give the high level. Addressing a target with a 10-bit address is done with plain byte writes: first the header byte `11110 a9 a8 0`, then the low address byte.

Top module: `twi_master`

## Requirements
- R1: The controller is enabled only while `ctl_mode` equals 3. Any other value releases both lines in the next cycle, aborts any command in progress and ignores new commands.
- R2: With no clock stretching, one bus-clock period is P = (lin+1)·2^exp cycles, and P must be at least 4. A start or stop command raises `done` P cycles after the cycle in which it was accepted. A write or read command raises `done` 9·P cycles after acceptance. For example, lin=14 and exp=3 give P=120.
- R3: A change in `div_lin` or `div_exp` restarts the period counter at zero on the next clock edge. A command in progress therefore completes its current period with the new P.
- R4: `cmd_op` encoding: 0 = start, 1 = write, 2 = read, 3 = stop. A start makes the data line fall while the clock line is high, and this also works as a repeated start. A stop makes the data line rise while the clock line is high. Byte commands change the data line only while the clock line is low.
- R5: A write sends `cmd_data` MSB first on eight clock pulses and samples the target's acknowledge on the ninth pulse. Any byte value can be sent, including a 10-bit address header `11110xx0` followed by the low address byte.
- R6: A high level sampled on the ninth pulse of a write sets `nack`, which stays set until `nack_clr` is 1 for a cycle. If a set and a clear happen in the same cycle, the set wins.
- R7: A read samples eight bits MSB first into `rd_data`, which is valid when `done` rises. On the ninth pulse the block pulls the data line low when `cmd_nack` = 0 (ACK) and releases it when `cmd_nack` = 1 (NACK).
- R8: A command is accepted only when `cmd_valid` is high, the block is enabled and `busy` is low. `busy` is high while the command executes. `done` is a one-cycle pulse in the cycle where `busy` has just returned low. A `cmd_valid` seen while busy has no effect.
- R9: While the block has released the clock line but the line reads low, the period counter holds. Each held cycle extends the command by exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz reference clock |
| rst | input | 1 | synchronous active-high reset |
| ctl_mode | input | 3 | mode selector; 3 enables the controller |
| div_lin | input | 4 | linear divider term (lin) |
| div_exp | input | 4 | power-of-two divider term (exp) |
| cmd_valid | input | 1 | command request |
| cmd_op | input | 2 | command code (0 start, 1 write, 2 read, 3 stop) |
| cmd_data | input | 8 | byte to transmit |
| cmd_nack | input | 1 | read only: 1 answers NACK, 0 answers ACK |
| nack_clr | input | 1 | write-one clear of the nack flag |
| scl_i | input | 1 | sensed level of the clock line |
| sda_i | input | 1 | sensed level of the data line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| busy | output | 1 | command in progress |
| done | output | 1 | one-cycle completion pulse |
| nack | output | 1 | sticky "no acknowledge" flag |
| rd_data | output | 8 | last byte received |

## Verification
The bench counts rising clock edges from the edge that accepts a command, and reads `done` on the falling edge that follows each count. It expects `done` after exactly P edges for start and stop, and after 9·P edges for byte commands. A stretch of K held cycles adds exactly K edges, and a divider change after edge k of a start ends the start after k+1+P' edges. The bench reads `rd_data` and `nack` on the same falling edge as `done`, since they are written at the completing edge. It expects the lines to be released one falling edge after the mode is dropped. Its target model reports start and stop conditions and the bytes and acknowledge bits it sees on the lines.

// File: rtl/twi_pkg.sv
package twi_pkg;

    // command codes seen on cmd_op
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } twi_op_e;

    // mode value that enables the controller
    localparam logic [2:0] MODE_TWI = 3'd3;

    // index of the acknowledge slot within a byte command
    localparam logic [3:0] ACK_SLOT = 4'd8;

    // timing events produced by the period divider
    typedef struct packed {
        logic at_quarter;   // data line may change (clock low)
        logic at_three_q;   // mid clock-high: start/stop edge
        logic at_end;       // end of period: sample point
        logic low_half;     // clock line is driven low
    } twi_tick_t;

    function automatic logic is_byte_op(twi_op_e op);
        return (op == OP_WRITE) || (op == OP_READ);
    endfunction

endpackage

// File: rtl/twi_divider.sv
module twi_divider
    import twi_pkg::*;
#(
    parameter int LIN_W = 4,
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [LIN_W-1:0] lin,
    input  logic [EXP_W-1:0] expo,
    input  logic             scl_in,
    output twi_tick_t        tick
);
    localparam int CNT_W = LIN_W + (1 << EXP_W);
    localparam logic [CNT_W-1:0] ONE = 1;

    logic [CNT_W-1:0]       cnt, period, half, qtr;
    logic [LIN_W+EXP_W-1:0] prev;
    logic                   chg, stall, adv;

    always_comb begin
        period = (CNT_W'(lin) + ONE) << expo;
        half   = period >> 1;
        qtr    = period >> 2;
        chg    = {lin, expo} != prev;
        stall  = (cnt >= half) && !scl_in;
        adv    = run && !chg && !stall;
        tick.at_quarter = adv && (cnt == qtr);
        tick.at_three_q = adv && (cnt == half + qtr);
        tick.at_end     = adv && (cnt == period - ONE);
        tick.low_half   = cnt < half;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            prev <= '0;
        end else begin
            prev <= {lin, expo};
            if (!run || chg)
                cnt <= '0;
            else if (adv)
                cnt <= (cnt == period - ONE) ? '0 : cnt + ONE;
        end
    end

    // R9: a target holding the clock low during the high phase freezes the count
    a_r9_stretch_freeze: assert property (@(posedge clk) disable iff (rst)
        (run && !chg && stall) |=> (!run || $stable(cnt)));

    // R3: a divider field change restarts the period
    a_r3_reload_zero: assert property (@(posedge clk) disable iff (rst)
        (run && chg) |=> (cnt == '0));

endmodule

// File: rtl/twi_engine.sv
module twi_engine
    import twi_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        cmd_valid,
    input  twi_op_e     cmd_op,
    input  logic [7:0]  cmd_data,
    input  logic        cmd_nack,
    input  logic        nack_clr,
    input  logic        sda_in,
    input  twi_tick_t   tick,
    output logic        busy,
    output logic        done,
    output logic        nack,
    output logic [7:0]  rd_data,
    output logic        scl_oe,
    output logic        sda_oe
);
    twi_op_e    op;
    logic [3:0] bitidx;
    logic [7:0] shreg;
    logic       rnack, bus_held, accept, last_bit;

    assign accept   = en && !busy && cmd_valid;
    assign last_bit = !is_byte_op(op) || (bitidx == ACK_SLOT);
    assign scl_oe   = busy && tick.low_half && ((op != OP_START) || bus_held);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            bus_held <= 1'b0;
            sda_oe   <= 1'b0;
            bitidx   <= '0;
            op       <= OP_START;
            shreg    <= '0;
            rnack    <= 1'b0;
            if (rst) rd_data <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy   <= 1'b1;
                op     <= cmd_op;
                shreg  <= cmd_data;
                rnack  <= cmd_nack;
                bitidx <= '0;
            end else if (busy) begin
                if (tick.at_quarter) begin
                    unique case (op)
                        OP_START: sda_oe <= 1'b0;
                        OP_STOP:  sda_oe <= 1'b1;
                        OP_WRITE: sda_oe <= (bitidx != ACK_SLOT) && !shreg[7];
                        OP_READ:  sda_oe <= (bitidx == ACK_SLOT) && !rnack;
                    endcase
                end
                if (tick.at_three_q) begin
                    if (op == OP_START) sda_oe <= 1'b1;
                    if (op == OP_STOP)  sda_oe <= 1'b0;
                end
                if (tick.at_end) begin
                    if (is_byte_op(op) && (bitidx != ACK_SLOT))
                        shreg <= {shreg[6:0], sda_in};
                    if (last_bit) begin
                        busy     <= 1'b0;
                        done     <= 1'b1;
                        bus_held <= (op != OP_STOP);
                        if (op == OP_READ) rd_data <= shreg;
                    end else begin
                        bitidx <= bitidx + 4'd1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            nack <= 1'b0;
        else if (busy && tick.at_end && (op == OP_WRITE) && (bitidx == ACK_SLOT) && sda_in)
            nack <= 1'b1;
        else if (nack_clr)
            nack <= 1'b0;
    end

    // R1: leaving the enabled mode frees both lines and the engine
    a_r1_idle_release: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!busy && !sda_oe && !scl_oe));

    // R6: nack holds until cleared
    a_r6_nack_sticky: assert property (@(posedge clk) disable iff (rst)
        (nack && !nack_clr) |=> nack);

    // R8: done only appears once the engine is idle
    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8: a command keeps running until its last sample point
    a_r8_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && en && !tick.at_end) |=> busy);

endmodule

// File: rtl/twi_master.sv
module twi_master
    import twi_pkg::*;
#(
    parameter int LIN_W = 4,
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       ctl_mode,
    input  logic [LIN_W-1:0] div_lin,
    input  logic [EXP_W-1:0] div_exp,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [7:0]       cmd_data,
    input  logic             cmd_nack,
    input  logic             nack_clr,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             busy,
    output logic             done,
    output logic             nack,
    output logic [7:0]       rd_data
);
    logic      en;
    twi_tick_t tick;

    assign en = (ctl_mode == MODE_TWI);

    twi_divider #(.LIN_W(LIN_W), .EXP_W(EXP_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .run    (busy),
        .lin    (div_lin),
        .expo   (div_exp),
        .scl_in (scl_i),
        .tick   (tick)
    );

    twi_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .cmd_valid (cmd_valid),
        .cmd_op    (twi_op_e'(cmd_op)),
        .cmd_data  (cmd_data),
        .cmd_nack  (cmd_nack),
        .nack_clr  (nack_clr),
        .sda_in    (sda_i),
        .tick      (tick),
        .busy      (busy),
        .done      (done),
        .nack      (nack),
        .rd_data   (rd_data),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

endmodule

// File: tb/twi_master_tb.sv
module twi_master_tb;
    timeunit 1ns;
    timeprecision 1ps;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst, cmd_valid, cmd_nack, nack_clr, hold;
    logic [2:0] ctl_mode;
    logic [3:0] lin, ex;
    logic [1:0] cmd_op;
    logic [7:0] cmd_data, rd_data;
    logic       scl_oe, sda_oe, busy, done, nack;
    logic       scl_line, sda_line, slv_pull;

    int errors = 0, checks = 0;

    // target model state
    int         bitcnt = 8, starts = 0, stops = 0;
    bit         active = 0, rd_q = 0, ack_q = 0, slv_read = 0, slv_ack = 0, ack_seen = 0;
    logic [7:0] slv_byte = 8'h00, cap = 8'h00;

    assign slv_pull = active && ((!rd_q && ack_q && bitcnt == 8) ||
                                 (rd_q && bitcnt < 8 && !slv_byte[7-bitcnt]));
    assign scl_line = !(scl_oe || hold);
    assign sda_line = !(sda_oe || slv_pull);

    twi_master u_dut (
        .clk(clk), .rst(rst), .ctl_mode(ctl_mode), .div_lin(lin), .div_exp(ex),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_nack(cmd_nack),
        .nack_clr(nack_clr), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done), .nack(nack),
        .rd_data(rd_data)
    );

    always @(negedge sda_line) if (scl_line === 1'b1) begin starts++; active = 1; bitcnt = 8; end
    always @(posedge sda_line) if (scl_line === 1'b1) begin stops++; active = 0; end
    always @(negedge scl_line) begin
        if (active) bitcnt = (bitcnt == 8) ? 0 : bitcnt + 1;
        rd_q  = slv_read;
        ack_q = slv_ack;
    end
    always @(posedge scl_line) if (active) begin
        if (bitcnt < 8) cap = {cap[6:0], sda_line};
        else            ack_seen = sda_line;
    end

    typedef struct packed {
        logic [3:0] lin;
        logic [3:0] ex;
        logic [1:0] op;
        logic [7:0] data;
        logic       rnack;
        logic       sack;
        logic       sread;
        logic [7:0] sbyte;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{4'd7,  4'd0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00},  // start
        '{4'd7,  4'd0, 2'd1, 8'hA6, 1'b0, 1'b1, 1'b0, 8'h00},  // write, acked
        '{4'd7,  4'd0, 2'd1, 8'h3C, 1'b0, 1'b0, 1'b0, 8'h00},  // write, not acked
        '{4'd14, 4'd3, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00},  // repeated start at 100 kbit/s
        '{4'd2,  4'd2, 2'd1, 8'hF4, 1'b0, 1'b1, 1'b0, 8'h00},  // 10-bit header
        '{4'd2,  4'd2, 2'd1, 8'h5A, 1'b0, 1'b1, 1'b0, 8'h00},  // 10-bit low byte
        '{4'd2,  4'd2, 2'd2, 8'h00, 1'b0, 1'b0, 1'b1, 8'h93},  // read, ACK
        '{4'd2,  4'd2, 2'd2, 8'h00, 1'b1, 1'b0, 1'b1, 8'h0F},  // read, NACK
        '{4'd14, 4'd1, 2'd3, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}   // stop at 400 kbit/s
    };

    function automatic int per(input logic [3:0] l, input logic [3:0] e);
        return (int'(l) + 1) << e;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [7:0] d, input logic rn, output int n);
        @(negedge clk);
        cmd_op = op; cmd_data = d; cmd_nack = rn; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!done && n < 20000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int n, s0, p0, expn;
        bit ok;
        rst = 1; ctl_mode = 3'd0; lin = 4'd7; ex = 4'd0; cmd_valid = 0; cmd_op = 0;
        cmd_data = 0; cmd_nack = 0; nack_clr = 0; hold = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // reset state (R8, R1)
        chk(!busy && !done && !nack, "R8 reset status", {busy, done, nack}, 0);
        chk(!scl_oe && !sda_oe, "R1 reset lines", {scl_oe, sda_oe}, 0);

        // disabled mode ignores commands (R1)
        ctl_mode = 3'd2; cmd_op = 2'd0; cmd_valid = 1;
        @(negedge clk) cmd_valid = 0;
        ok = 1;
        repeat (20) begin @(negedge clk); if (busy || done || scl_oe || sda_oe) ok = 0; end
        chk(ok, "R1 mode ignored", ok, 1);

        // table of transactions (R2, R4, R5, R6, R7)
        ctl_mode = 3'd3;
        for (int i = 0; i < 9; i++) begin
            vec_t v;
            v = VECS[i];
            lin = v.lin; ex = v.ex; slv_ack = v.sack; slv_read = v.sread; slv_byte = v.sbyte;
            s0 = starts; p0 = stops;
            run_cmd(v.op, v.data, v.rnack, n);
            expn = per(v.lin, v.ex) * ((v.op == 2'd1 || v.op == 2'd2) ? 9 : 1);
            chk(n == expn, "R2 latency", n, expn);
            chk(starts - s0 == int'(v.op == 2'd0), "R4 start count", starts - s0, int'(v.op == 2'd0));
            chk(stops - p0 == int'(v.op == 2'd3), "R4 stop count", stops - p0, int'(v.op == 2'd3));
            if (v.op == 2'd1) begin
                chk(cap == v.data, "R5 byte on bus", cap, v.data);
                chk(nack == !v.sack, "R6 nack flag", nack, !v.sack);
                if (nack) begin
                    @(negedge clk) nack_clr = 1;
                    @(negedge clk) nack_clr = 0;
                    chk(!nack, "R6 nack cleared", nack, 0);
                end
            end
            if (v.op == 2'd2) begin
                chk(rd_data == v.sbyte, "R7 read byte", rd_data, v.sbyte);
                chk(ack_seen == v.rnack, "R7 ninth bit", ack_seen, v.rnack);
            end
        end

        // clock stretching (R9): P=8, H=4, held K=6 extra cycles
        lin = 4'd7; ex = 4'd0; slv_ack = 1; slv_read = 0;
        run_cmd(2'd0, 8'h00, 1'b0, n);
        fork
            run_cmd(2'd1, 8'hA5, 1'b0, n);
            begin
                @(negedge clk); @(negedge clk);
                hold = 1;
                repeat (4 + 6) @(posedge clk);
                @(negedge clk) hold = 0;
            end
        join
        chk(n == 9 * 8 + 6, "R9 stretch latency", n, 78);
        chk(cap == 8'hA5, "R9 byte after stretch", cap, 8'hA5);
        slv_ack = 0;
        run_cmd(2'd3, 8'h00, 1'b0, n);

        // divider reload mid-start (R3): change after 3 edges, new P=12
        fork
            run_cmd(2'd0, 8'h00, 1'b0, n);
            begin
                @(negedge clk); @(negedge clk);
                repeat (3) @(posedge clk);
                @(negedge clk) begin lin = 4'd2; ex = 4'd2; end
            end
        join
        chk(n == 3 + 1 + 12, "R3 reload latency", n, 16);

        // command while busy is ignored (R8)
        p0 = stops;
        fork
            run_cmd(2'd0, 8'h00, 1'b0, n);
            begin
                @(negedge clk); @(negedge clk); @(negedge clk);
                cmd_op = 2'd3; cmd_valid = 1;
                @(negedge clk) cmd_valid = 0;
            end
        join
        chk(n == 12, "R8 busy latency", n, 12);
        ok = 1;
        repeat (20) begin @(negedge clk); if (busy || done) ok = 0; end
        chk(ok && stops == p0, "R8 busy ignore", stops - p0, 0);

        // mode dropped mid-write (R1)
        @(negedge clk) begin cmd_op = 2'd1; cmd_data = 8'h00; cmd_valid = 1; end
        @(negedge clk) cmd_valid = 0;
        repeat (5) @(negedge clk);
        chk(busy, "R1 write started", busy, 1);
        ctl_mode = 3'd0;
        @(negedge clk);
        chk(!busy && !scl_oe && !sda_oe, "R1 abort release", {busy, scl_oe, sda_oe}, 0);

        finish_run();
    end
endmodule